// File: doc/BRIEF.md
# Circular Descriptor Ring Fetch Engine

This block is a single-channel engine that walks a circular ring of 8-byte transfer descriptors kept in a small local descriptor store. Software writes descriptors into ring slots, programs a pipe control register once, and then moves the end of the work list forward by writing an absolute byte offset into a doorbell. The engine takes descriptors one after another, starting at its current offset and stopping when it reaches the doorbell offset. For each descriptor it presents a transfer request that carries address, length and direction, and holds the request until a done handshake arrives.

After each completed descriptor the engine advances its current offset, which software can read, by one 8-byte slot with wraparound. It pulses an event for every processed descriptor, plus an interrupt-request event and an end-of-transfer event when the descriptor's flags ask for them. A halt input pauses the fetch of new descriptors. A descriptor with an illegal length stops the pipe with an error pulse. A per-pipe reset returns every pipe register and all ring state to defaults, and it is the only way to disable an enabled pipe. The producer must leave one ring slot unused, so a ring of N slots holds at most N-1 pending descriptors.

Top module: `desc_ring_engine`

## Requirements
- R1: A descriptor word is 64 bits: bits [31:0] hold the buffer address, bits [47:32] the byte length and bits [63:48] the flags. The request shows the address on req_addr and the length on req_len, and req_dir equals bit 3 of the control register (1 = device to memory).
- R2: Control bits are: bit 1 enable, bit 3 direction, bit 5 system mode. All other bits read back as 0. A write is accepted only while bit 1 is clear; once the pipe is enabled, further control writes are ignored. A disabled pipe issues no request.
- R3: The doorbell takes a byte offset. Bits [2:0] are ignored and the offset is taken modulo the ring size in bytes (SLOTS*8). While the current offset equals the doorbell offset, the engine is idle and issues no request.
- R4: When req_done is sampled high during a request, the current offset advances by 8 modulo the ring size in the next cycle. In that same cycle ev_desc pulses for one cycle, ev_irq pulses too if flag bit 15 is set, and ev_eot pulses too if flag bit 14 is set. Flag bit 13 (end of block) raises no event.
- R5: cur_ofs gives the current ring position as a byte offset (slot index times 8). It reads 0 after any reset.
- R6: A doorbell write while descriptors are still pending only moves the end point. Processing continues in order from the current offset, including across the ring wrap.
- R7: While halt is high, no new descriptor is fetched. A request already issued still completes normally. When halt goes low, processing resumes at the current offset.
- R8: A descriptor with length 0 or length above 32760 produces a one-cycle err_pulse and no request. The pipe then stays stopped with its offset on the failing descriptor until it is reset.
- R9: While pipe_rst is high, the control register, the current offset, the doorbell offset, any outstanding request and all event outputs are cleared at the next clock edge.
- R10: A synchronous active-low rst_n gives the same defaults as R9.
- R11: Once req_valid is high, it stays high with req_addr and req_len unchanged until req_done is sampled high, unless a reset intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_we | input | 1 | Write strobe for the descriptor store |
| desc_slot | input | SLOT_W | Slot index to write |
| desc_wdata | input | 64 | Descriptor word (flags, length, address) |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write value |
| ctrl_q | output | 8 | Control register readback |
| pipe_rst | input | 1 | Per-pipe reset, active high |
| halt | input | 1 | Pause new descriptor fetches |
| db_we | input | 1 | Doorbell write strobe |
| db_wdata | input | 16 | Doorbell byte offset |
| cur_ofs | output | 16 | Current ring byte offset |
| req_valid | output | 1 | Transfer request pending |
| req_addr | output | 32 | Request buffer address |
| req_len | output | 16 | Request byte length |
| req_dir | output | 1 | Request direction, 1 = device to memory |
| req_done | input | 1 | Transfer completion handshake |
| ev_desc | output | 1 | Descriptor processed pulse |
| ev_irq | output | 1 | Interrupt request pulse |
| ev_eot | output | 1 | End-of-transfer pulse |
| err_pulse | output | 1 | Illegal descriptor length pulse |

## Verification
The assertions assume that req_done is only raised while req_valid is high. The bench's responder drives req_done for exactly one cycle, and only after it has seen a pending request. The assertions also assume that the producer never rings past the slot before the current offset and never rewrites a slot that is being fetched. The stimulus writes every descriptor before ringing the doorbell that covers it, and it keeps at most SLOTS-1 descriptors outstanding.

// File: rtl/ring_pkg.sv
// Shared types and field positions for the descriptor ring engine.
// Assumes descriptors are 64-bit words with flags in the top half-word.
package ring_pkg;

    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] size;
        logic [31:0] addr;
    } desc_t;

    localparam int FLAG_IRQ  = 15;
    localparam int FLAG_EOT  = 14;
    localparam int FLAG_EOB  = 13;

    localparam int CTRL_EN   = 1;
    localparam int CTRL_DIR  = 3;
    localparam int CTRL_SYS  = 5;
    localparam logic [7:0] CTRL_MASK = 8'h2A;

    localparam logic [15:0] MAX_LEN = 16'd32760;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_REQ   = 2'd2,
        ST_STOP  = 2'd3
    } eng_state_t;

endpackage

// File: rtl/ring_desc_store.sv
// Local descriptor storage: one write port for software, one registered
// read port for the engine. Assumes writes and reads target distinct slots.
module ring_desc_store
    import ring_pkg::*;
#(
    parameter int SLOTS  = 16,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [SLOT_W-1:0] waddr,
    input  desc_t             wdata,
    input  logic              re,
    input  logic [SLOT_W-1:0] raddr,
    output desc_t             rdata
);

    desc_t mem [SLOTS];

    // Software write into the ring slot.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read; output holds until the next read.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/ring_pointers.sv
// Current and doorbell slot pointers. The pointers wrap naturally because
// SLOTS is a power of two. Both clear on either reset.
module ring_pointers #(
    parameter int SLOTS  = 16,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_rst,
    input  logic              db_we,
    input  logic [SLOT_W-1:0] db_slot,
    input  logic              advance,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              pending
);

    logic [SLOT_W-1:0] end_slot;

    // Doorbell capture and one-slot advance on completion.
    always_ff @(posedge clk) begin
        if (!rst_n || pipe_rst) begin
            cur_slot <= '0;
            end_slot <= '0;
        end else begin
            if (db_we)   end_slot <= db_slot;
            if (advance) cur_slot <= cur_slot + 1'b1;
        end
    end

    // Work remains while the pointers differ.
    always_comb pending = (cur_slot != end_slot);

endmodule

// File: rtl/ring_fetch_fsm.sv
// Sequencer: fetches one descriptor, checks its length, holds the request
// until done, and then emits completion pulses. Assumes req_done only
// arrives while a request is pending.
module ring_fetch_fsm
    import ring_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pipe_rst,
    input  logic  enable,
    input  logic  halt,
    input  logic  pending,
    input  desc_t rd_desc,
    input  logic  req_done,
    output logic  rd_en,
    output logic  advance,
    output logic  req_valid,
    output logic  ev_desc,
    output logic  ev_irq,
    output logic  ev_eot,
    output logic  err_pulse
);

    eng_state_t state;
    logic       size_bad;
    logic       unused_flags;

    assign unused_flags = ^{rd_desc.flags[FLAG_EOB:0], rd_desc.addr};

    // Start a fetch only when idle, enabled, unpaused and work remains.
    always_comb rd_en = (state == ST_IDLE) && enable && pending && !halt;

    // Length legality check on the fetched descriptor.
    always_comb size_bad = (rd_desc.size == 16'd0) || (rd_desc.size > MAX_LEN);

    always_comb req_valid = (state == ST_REQ);
    always_comb advance   = (state == ST_REQ) && req_done;

    // State sequencing; stop is left only through a reset.
    always_ff @(posedge clk) begin
        if (!rst_n || pipe_rst) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (rd_en) state <= ST_FETCH;
                ST_FETCH: state <= size_bad ? ST_STOP : ST_REQ;
                ST_REQ:   if (req_done) state <= ST_IDLE;
                ST_STOP:  state <= ST_STOP;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // One-cycle completion and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || pipe_rst) begin
            ev_desc   <= 1'b0;
            ev_irq    <= 1'b0;
            ev_eot    <= 1'b0;
            err_pulse <= 1'b0;
        end else begin
            ev_desc   <= advance;
            ev_irq    <= advance && rd_desc.flags[FLAG_IRQ];
            ev_eot    <= advance && rd_desc.flags[FLAG_EOT];
            err_pulse <= (state == ST_FETCH) && size_bad;
        end
    end

endmodule

// File: rtl/desc_ring_engine.sv
// Top of the single-channel descriptor ring engine. Holds the write-once
// control register and joins the store, pointers and sequencer.
// Assumes SLOTS is a power of two and SLOTS*8 fits in 16 bits.
module desc_ring_engine
    import ring_pkg::*;
#(
    parameter int SLOTS  = 16,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_we,
    input  logic [SLOT_W-1:0] desc_slot,
    input  logic [63:0]       desc_wdata,
    input  logic              ctrl_we,
    input  logic [7:0]        ctrl_wdata,
    output logic [7:0]        ctrl_q,
    input  logic              pipe_rst,
    input  logic              halt,
    input  logic              db_we,
    input  logic [15:0]       db_wdata,
    output logic [15:0]       cur_ofs,
    output logic              req_valid,
    output logic [31:0]       req_addr,
    output logic [15:0]       req_len,
    output logic              req_dir,
    input  logic              req_done,
    output logic              ev_desc,
    output logic              ev_irq,
    output logic              ev_eot,
    output logic              err_pulse
);

    logic [SLOT_W-1:0] cur_slot;
    logic              pending;
    logic              rd_en;
    logic              advance;
    desc_t             rd_desc;
    logic              unused_db;

    assign unused_db = ^{db_wdata[15:SLOT_W+3], db_wdata[2:0]};

    // Control register: writable only until the enable bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n || pipe_rst) begin
            ctrl_q <= 8'h00;
        end else if (ctrl_we && !ctrl_q[CTRL_EN]) begin
            ctrl_q <= ctrl_wdata & CTRL_MASK;
        end
    end

    ring_desc_store #(.SLOTS(SLOTS)) u_store (
        .clk   (clk),
        .we    (desc_we),
        .waddr (desc_slot),
        .wdata (desc_t'(desc_wdata)),
        .re    (rd_en),
        .raddr (cur_slot),
        .rdata (rd_desc)
    );

    ring_pointers #(.SLOTS(SLOTS)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .pipe_rst (pipe_rst),
        .db_we    (db_we),
        .db_slot  (db_wdata[SLOT_W+2:3]),
        .advance  (advance),
        .cur_slot (cur_slot),
        .pending  (pending)
    );

    ring_fetch_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_rst  (pipe_rst),
        .enable    (ctrl_q[CTRL_EN]),
        .halt      (halt),
        .pending   (pending),
        .rd_desc   (rd_desc),
        .req_done  (req_done),
        .rd_en     (rd_en),
        .advance   (advance),
        .req_valid (req_valid),
        .ev_desc   (ev_desc),
        .ev_irq    (ev_irq),
        .ev_eot    (ev_eot),
        .err_pulse (err_pulse)
    );

    // Request fields come straight from the fetched descriptor.
    always_comb begin
        req_addr = rd_desc.addr;
        req_len  = rd_desc.size;
        req_dir  = ctrl_q[CTRL_DIR];
    end

    // Byte offset view of the current slot.
    always_comb cur_ofs = 16'({cur_slot, 3'b000});

endmodule

// File: rtl/ring_engine_checker.sv
// Temporal checks on the ring engine's ports, bound to the top module.
module ring_engine_checker #(
    parameter int SLOTS = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        pipe_rst,
    input logic [7:0]  ctrl_q,
    input logic [15:0] cur_ofs,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic [15:0] req_len,
    input logic        req_done,
    input logic        ev_desc,
    input logic        ev_irq,
    input logic        ev_eot,
    input logic        err_pulse
);

    localparam logic [15:0] OFS_MASK = 16'(SLOTS * 8 - 1);

    // R11: request held steady until completion
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n || pipe_rst)
        req_valid && !req_done |=> req_valid && $stable(req_addr) && $stable(req_len));

    // R4: offset steps by one slot with each processed descriptor
    p_ofs_step_r4: assert property (@(posedge clk) disable iff (!rst_n || pipe_rst)
        ev_desc |-> cur_ofs == (($past(cur_ofs) + 16'd8) & OFS_MASK));

    // R4: flag events only accompany a processed descriptor
    p_flag_ev_r4: assert property (@(posedge clk) disable iff (!rst_n || pipe_rst)
        (ev_irq || ev_eot) |-> ev_desc);

    // R2: a disabled pipe is silent
    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n || pipe_rst)
        !ctrl_q[1] |-> !req_valid && !ev_desc);

    // R2: enable is sticky and freezes the control register
    p_enable_once_r2: assert property (@(posedge clk) disable iff (!rst_n || pipe_rst)
        ctrl_q[1] |=> ctrl_q[1] && $stable(ctrl_q));

    // R8: only legal lengths reach the request
    p_len_legal_r8: assert property (@(posedge clk) disable iff (!rst_n || pipe_rst)
        req_valid |-> (req_len != 16'd0) && (req_len <= 16'd32760));

    // R8: after an error no request follows
    p_err_stop_r8: assert property (@(posedge clk) disable iff (!rst_n || pipe_rst)
        err_pulse |=> !req_valid && !ev_desc);

endmodule

bind desc_ring_engine ring_engine_checker #(.SLOTS(SLOTS)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_rst  (pipe_rst),
    .ctrl_q    (ctrl_q),
    .cur_ofs   (cur_ofs),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_done  (req_done),
    .ev_desc   (ev_desc),
    .ev_irq    (ev_irq),
    .ev_eot    (ev_eot),
    .err_pulse (err_pulse)
);

// File: tb/desc_ring_engine_test.sv
// Bench: table-driven descriptor walk followed by directed corner tests.
module desc_ring_engine_test;

    localparam int SLOTS  = 16;
    localparam int SLOT_W = $clog2(SLOTS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              desc_we = 1'b0;
    logic [SLOT_W-1:0] desc_slot = '0;
    logic [63:0]       desc_wdata = '0;
    logic              ctrl_we = 1'b0;
    logic [7:0]        ctrl_wdata = '0;
    logic [7:0]        ctrl_q;
    logic              pipe_rst = 1'b0;
    logic              halt = 1'b0;
    logic              db_we = 1'b0;
    logic [15:0]       db_wdata = '0;
    logic [15:0]       cur_ofs;
    logic              req_valid;
    logic [31:0]       req_addr;
    logic [15:0]       req_len;
    logic              req_dir;
    logic              req_done = 1'b0;
    logic              ev_desc, ev_irq, ev_eot, err_pulse;

    int  nvec = 0;
    int  nbad = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    desc_ring_engine #(.SLOTS(SLOTS)) uut (.*);

    // Table: {flags, size, addr}, loaded into slots 0..5
    localparam logic [63:0] VEC [6] = '{
        {16'h8000, 16'd64,    32'h1000_0000},
        {16'h4000, 16'd1,     32'h2000_0040},
        {16'hC000, 16'd32760, 32'h3000_0100},
        {16'h2000, 16'd8,     32'h4000_0200},
        {16'h0000, 16'd512,   32'hDEAD_BEE0},
        {16'hE000, 16'd2,     32'h0000_0008}
    };

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic put_desc(input int slot, input logic [63:0] w);
        @(negedge clk);
        desc_we = 1'b1; desc_slot = SLOT_W'(slot); desc_wdata = w;
        @(negedge clk);
        desc_we = 1'b0;
    endtask

    task automatic ring(input logic [15:0] ofs);
        @(negedge clk);
        db_we = 1'b1; db_wdata = ofs;
        @(negedge clk);
        db_we = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic prst();
        @(negedge clk);
        pipe_rst = 1'b1;
        @(negedge clk);
        pipe_rst = 1'b0;
    endtask

    task automatic wait_req(output bit got);
        got = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (req_valid) begin got = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    // Serve one request and check fields and the following pulses.
    task automatic serve(input string rq, input logic [63:0] d, input logic [15:0] exp_ofs);
        bit got;
        wait_req(got);
        chk({rq, " R1 request seen"}, got, 1'b1);
        chk({rq, " R1 addr"}, req_addr, d[31:0]);
        chk({rq, " R1 len"}, req_len, d[47:32]);
        repeat (2) @(negedge clk);
        chk({rq, " R11 hold"}, {req_valid, req_addr}, {1'b1, d[31:0]});
        req_done = 1'b1;
        @(negedge clk);
        req_done = 1'b0;
        chk({rq, " R4 ev_desc"}, ev_desc, 1'b1);
        chk({rq, " R4 ev_irq"}, ev_irq, d[63]);
        chk({rq, " R4 ev_eot"}, ev_eot, d[62]);
        chk({rq, " R5 cur_ofs"}, cur_ofs, exp_ofs);
        @(negedge clk);
        chk({rq, " R4 single pulse"}, ev_desc, 1'b0);
    endtask

    function automatic logic [63:0] wrap_desc(input int s);
        return {(s == 15) ? 16'h8000 : 16'h0000, 16'(s + 1), 32'h5000_0000 + 32'(s * 256)};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nvec++; nbad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        bit got;
        bit saw_err;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset defaults
        chk("R10 ctrl", ctrl_q, 8'h00);
        chk("R10 cur_ofs", cur_ofs, 16'h0);
        chk("R10 quiet", {req_valid, ev_desc, err_pulse}, 3'b000);

        // Load table while disabled; doorbell must not start anything
        for (int i = 0; i < 6; i++) put_desc(i, VEC[i]);
        ring(16'd48);
        repeat (6) @(negedge clk);
        chk("R2 disabled no request", req_valid, 1'b0);

        wr_ctrl(8'hFF);
        chk("R2 ctrl mask", ctrl_q, 8'h2A);
        for (int i = 0; i < 6; i++) begin
            serve($sformatf("vec%0d", i), VEC[i], 16'((i + 1) * 8));
            chk("R1 dir", req_dir, 1'b1);
        end

        // R3 idle at doorbell
        repeat (8) @(negedge clk);
        chk("R3 idle", {req_valid, cur_ofs}, {1'b0, 16'd48});

        // R2 enable once
        wr_ctrl(8'h00);
        chk("R2 write ignored", ctrl_q, 8'h2A);

        // R6 extension across wrap; R3 modulo doorbell
        for (int s = 6; s < 16; s++) put_desc(s, wrap_desc(s));
        put_desc(0, wrap_desc(0));
        put_desc(1, wrap_desc(1));
        ring(16'd80);
        serve("R6 first", wrap_desc(6), 16'd56);
        ring(16'h0095);   // 149: slot 2 after dropping low bits and wrapping (R3)
        for (int s = 7; s < 16; s++) serve("R6 ext", wrap_desc(s), 16'(((s + 1) % 16) * 8));
        serve("R6 wrapped", wrap_desc(0), 16'd8);
        serve("R6 wrapped", wrap_desc(1), 16'd16);
        repeat (6) @(negedge clk);
        chk("R3 idle after wrap", {req_valid, cur_ofs}, {1'b0, 16'd16});

        // R7 halt blocks new fetches
        halt = 1'b1;
        put_desc(2, {16'h4000, 16'd100, 32'hA000_0000});
        ring(16'd24);
        repeat (8) @(negedge clk);
        chk("R7 halted", {req_valid, cur_ofs}, {1'b0, 16'd16});
        halt = 1'b0;
        serve("R7 resume", {16'h4000, 16'd100, 32'hA000_0000}, 16'd24);

        // R7 halt during an issued request still completes
        put_desc(3, {16'h0000, 16'd4, 32'hB000_0000});
        ring(16'd32);
        wait_req(got);
        halt = 1'b1;
        serve("R7 in-flight", {16'h0000, 16'd4, 32'hB000_0000}, 16'd32);
        halt = 1'b0;

        // R8 zero length stops the pipe
        put_desc(4, {16'h8000, 16'd0, 32'hC000_0000});
        put_desc(5, {16'h0000, 16'd8, 32'hC000_1000});
        ring(16'd48);
        saw_err = 1'b0; got = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (err_pulse) saw_err = 1'b1;
            if (req_valid) got = 1'b1;
        end
        chk("R8 zero length err", saw_err, 1'b1);
        chk("R8 no request", got, 1'b0);
        chk("R8 offset held", cur_ofs, 16'd32);

        // R9 pipe reset clears everything
        prst();
        chk("R9 ctrl cleared", ctrl_q, 8'h00);
        chk("R9 offset cleared", cur_ofs, 16'd0);

        // R8 oversize length
        put_desc(0, {16'h0000, 16'd32761, 32'hD000_0000});
        wr_ctrl(8'h02);
        chk("R1 dir memory-to-device", req_dir, 1'b0);
        ring(16'd8);
        saw_err = 1'b0; got = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (err_pulse) saw_err = 1'b1;
            if (req_valid) got = 1'b1;
        end
        chk("R8 oversize err", {saw_err, got}, 2'b10);

        // R9 reset withdraws a pending request
        prst();
        put_desc(0, {16'h0000, 16'd16, 32'hE000_0000});
        wr_ctrl(8'h0A);
        ring(16'd8);
        wait_req(got);
        chk("R9 request before reset", got, 1'b1);
        prst();
        chk("R9 request withdrawn", {req_valid, ev_desc, cur_ofs}, {2'b00, 16'd0});

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule